// File: doc/BRIEF.md
# Multi-Channel Packet-Buffered Stream FIFO

This block stores several independent streams in one shared RAM. The RAM is split into one fixed segment per channel, each 2^ADDR_W words deep. Writers deliver beats on a ready/valid input that carries a channel number, start-of-packet and end-of-packet markers and an error field. The block hands the beats back in order on a ready/valid output with the same sideband. An output request input chooses the channel that the output serves.

With packet buffering enabled, a channel shows new words to the output only after the last beat of the packet has been stored. Each channel keeps a committed and a speculative write pointer for this. A packet that carries an error on any beat can be discarded by winding the speculative pointer back to the committed one. With packet support off, a channel starts delivering only when its readable word count reaches a programmable section threshold.

A small register port selects a channel and reports its fill level and four threshold flags (two almost-full, two almost-empty). The thresholds are written through the same port.

Top module: `mcf_shared_fifo`

## Requirements
- R1: Each channel holds at most 2^ADDR_W words (8 by default). When a channel is full, in_ready is low while in_ch names that channel and stays high for a channel with free space. Data is never overwritten.
- R2: Each channel returns its words in arrival order, with data, error, start marker (out_sop) and end marker (out_eop) unchanged.
- R3: In packet-buffer mode a channel presents no word at the output until the end-of-packet beat of that packet has been accepted.
- R4: With drop-on-error active, a packet with a nonzero error field on any beat is discarded completely. Its words are never output, and its space is freed when its end beat is accepted.
- R5: req_ch selects the channel from which the next word is fetched, and out_ch reports the channel of the word on the output.
- R6: While out_valid is high and out_ready is low, out_valid, out_data, out_err, out_sop, out_eop and out_ch hold their values.
- R7: Status register map (csr_addr): 0 channel select, 1 fill level, 2 flags, 3 almost-full 1, 4 almost-full 2, 5 almost-empty 1, 6 almost-empty 2, 7 section threshold. The fill level counts the words of the selected channel written into its segment (committed or not) and not yet moved to the output stage. csr_rdata shows the register named by csr_addr one clock later.
- R8: Flag register bits: bit 0 is fill >= almost-full 1, bit 1 is fill >= almost-full 2, bit 2 is fill <= almost-empty 1, bit 3 is fill <= almost-empty 2. A threshold that is not enabled reads 0, ignores writes, and its flag stays 0.
- R9: With packet support off, a word is fetched only while the channel's readable count is at least the section threshold (a threshold of 0 acts as 1). The output start and end markers are 0.
- R10: After reset the output is idle, every channel is empty with in_ready high, and all threshold and select registers read 0.
- R11: Without the request input and with more than one channel, only channel 0 is ever output. Words written to other channels stay in their segments.
- R12: With drop-on-error inactive (always so when packet buffering is off), beats with a nonzero error field are stored and output with that error value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge if valid |
| in_data | input | DATA_W | Input payload |
| in_ch | input | CH_W | Channel of the input beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_err | input | ERR_SZ | Error field of the beat |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word consumed on this edge if valid |
| out_data | output | DATA_W | Output payload |
| out_ch | output | CH_W | Channel of the output word |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_err | output | ERR_SZ | Error field of the output word |
| req_ch | input | CH_W | Channel the output should serve |
| csr_addr | input | 3 | Status register index |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | CSR_W | Register write data |
| csr_rdata | output | CSR_W | Register read data, one clock after csr_addr |

## Verification
The assertions assume that in_ch and req_ch always name an existing channel. They also assume that no packet is longer than one segment, because such a packet would stall the input forever rather than overflow. The stimulus uses only channels 0 and 1 and keeps every packet at eight beats or fewer. Errored beats are placed inside complete packets so that each drop ends on an end beat. Input fields change only at falling edges, and the bench holds them until the beat is accepted, which matches the hold-while-not-ready behaviour that the output assertion relies on from the consumer's side.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam logic [2:0] CSR_CHSEL = 3'd0;
    localparam logic [2:0] CSR_FILL  = 3'd1;
    localparam logic [2:0] CSR_FLAGS = 3'd2;
    localparam logic [2:0] CSR_AF1   = 3'd3;
    localparam logic [2:0] CSR_AF2   = 3'd4;
    localparam logic [2:0] CSR_AE1   = 3'd5;
    localparam logic [2:0] CSR_AE2   = 3'd6;
    localparam logic [2:0] CSR_SECT  = 3'd7;

    localparam int FLG_AF1 = 0;
    localparam int FLG_AF2 = 1;
    localparam int FLG_AE1 = 2;
    localparam int FLG_AE2 = 3;
endpackage

// File: rtl/mcf_seg_ram.sv
module mcf_seg_ram #(
    parameter int AW = 4,
    parameter int W  = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int WORDS = 1 << AW;

    logic [W-1:0] mem [WORDS];
    logic [W-1:0] rdata_q;

    // storage array: no reset, one write and one registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mcf_chan_ptrs.sv
module mcf_chan_ptrs #(
    parameter int ADDR_W   = 3,
    parameter bit PKT_EFF  = 1'b1,
    parameter bit DROP_EFF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_eop,
    input  logic              err_nz,
    input  logic              rd_en,
    output logic [ADDR_W:0]   occ,
    output logic [ADDR_W:0]   vis,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] spec;
        logic [PW-1:0] cmt;
        logic [PW-1:0] rd;
        logic          drop;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.spec = st_q.spec + 1'b1;
            if (DROP_EFF && err_nz) begin
                st_d.drop = 1'b1;
            end
            if (!PKT_EFF) begin
                st_d.cmt = st_q.spec + 1'b1;
            end else if (wr_eop) begin
                if (DROP_EFF && (st_q.drop || err_nz)) begin
                    st_d.spec = st_q.cmt;
                    st_d.drop = 1'b0;
                end else begin
                    st_d.cmt = st_q.spec + 1'b1;
                end
            end
        end
        if (rd_en) begin
            st_d.rd = st_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ    = st_q.spec - st_q.rd;
    assign vis    = st_q.cmt - st_q.rd;
    assign wr_ptr = st_q.spec[ADDR_W-1:0];
    assign rd_ptr = st_q.rd[ADDR_W-1:0];

    // R1: the segment never holds more than its depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ) <= DEPTH);

    // R3: committed words are never ahead of the written ones
    p_vis_le_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vis <= occ);

    // R3: in packet mode the commit pointer moves only on an end beat
    p_commit_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PKT_EFF && !(wr_en && wr_eop)) |=> $stable(st_q.cmt));

    // R4: a dropped packet rewinds the write pointer to the commit point
    p_drop_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (DROP_EFF && wr_en && wr_eop && (st_q.drop || err_nz))
            |=> (st_q.spec == $past(st_q.cmt)));
endmodule

// File: rtl/mcf_status_regs.sv
module mcf_status_regs
    import mcf_pkg::*;
#(
    parameter int CH_W   = 1,
    parameter int PW     = 4,
    parameter int CSR_W  = 4,
    parameter int NUM_AF = 2,
    parameter int NUM_AE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic [PW-1:0]    fill,
    output logic [CH_W-1:0]  chsel,
    output logic [PW-1:0]    sect,
    output logic [CSR_W-1:0] rdata
);
    typedef struct packed {
        logic [CH_W-1:0]  chsel;
        logic [PW-1:0]    af1;
        logic [PW-1:0]    af2;
        logic [PW-1:0]    ae1;
        logic [PW-1:0]    ae2;
        logic [PW-1:0]    sect;
        logic [CSR_W-1:0] rdata;
    } csr_st_t;

    csr_st_t     st_d, st_q;
    logic [3:0]  flags;
    logic [PW-1:0] w_pw;

    assign w_pw = wdata[PW-1:0];

    always_comb begin
        flags          = '0;
        flags[FLG_AF1] = (NUM_AF >= 1) && (fill >= st_q.af1);
        flags[FLG_AF2] = (NUM_AF >= 2) && (fill >= st_q.af2);
        flags[FLG_AE1] = (NUM_AE >= 1) && (fill <= st_q.ae1);
        flags[FLG_AE2] = (NUM_AE >= 2) && (fill <= st_q.ae2);
    end

    always_comb begin
        st_d = st_q;
        unique case (addr)
            CSR_CHSEL: st_d.rdata = CSR_W'(st_q.chsel);
            CSR_FILL:  st_d.rdata = CSR_W'(fill);
            CSR_FLAGS: st_d.rdata = CSR_W'(flags);
            CSR_AF1:   st_d.rdata = CSR_W'(st_q.af1);
            CSR_AF2:   st_d.rdata = CSR_W'(st_q.af2);
            CSR_AE1:   st_d.rdata = CSR_W'(st_q.ae1);
            CSR_AE2:   st_d.rdata = CSR_W'(st_q.ae2);
            default:   st_d.rdata = CSR_W'(st_q.sect);
        endcase
        if (wr) begin
            unique case (addr)
                CSR_CHSEL: st_d.chsel = wdata[CH_W-1:0];
                CSR_AF1:   if (NUM_AF >= 1) st_d.af1 = w_pw;
                CSR_AF2:   if (NUM_AF >= 2) st_d.af2 = w_pw;
                CSR_AE1:   if (NUM_AE >= 1) st_d.ae1 = w_pw;
                CSR_AE2:   if (NUM_AE >= 2) st_d.ae2 = w_pw;
                CSR_SECT:  st_d.sect = w_pw;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chsel = st_q.chsel;
    assign sect  = st_q.sect;
    assign rdata = st_q.rdata;

    // R8: a threshold that is not enabled keeps its reset value
    p_af2_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_AF < 2) |-> (st_q.af2 == '0));
endmodule

// File: rtl/mcf_shared_fifo.sv
module mcf_shared_fifo
    import mcf_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int ERR_W    = 2,
    parameter bit USE_PKT  = 1'b1,
    parameter bit PKT_BUF  = 1'b1,
    parameter bit DROP_ERR = 1'b1,
    parameter int NUM_AF   = 2,
    parameter int NUM_AE   = 2,
    parameter bit USE_REQ  = 1'b1,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ERR_SZ  = (ERR_W > 0) ? ERR_W : 1,
    localparam int PW      = ADDR_W + 1,
    localparam int CSR_W   = (PW > 4) ? ((PW > CH_W) ? PW : CH_W) : ((CH_W > 4) ? CH_W : 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CH_W-1:0]   in_ch,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [ERR_SZ-1:0] in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_ch,
    output logic              out_sop,
    output logic              out_eop,
    output logic [ERR_SZ-1:0] out_err,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [2:0]        csr_addr,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata
);
    localparam bit PKT_EFF  = USE_PKT && PKT_BUF;
    localparam bit DROP_EFF = PKT_EFF && DROP_ERR;
    localparam int WORD_W   = DATA_W + 2 + ERR_SZ;
    localparam int RAM_AW   = CH_W + ADDR_W;

    typedef struct packed {
        logic            out_valid;
        logic [CH_W-1:0] out_ch;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [PW-1:0]     occ_v  [NUM_CH];
    logic [PW-1:0]     vis_v  [NUM_CH];
    logic [ADDR_W-1:0] wptr_v [NUM_CH];
    logic [ADDR_W-1:0] rptr_v [NUM_CH];
    logic [NUM_CH-1:0] wr_sel, rd_sel, avail_v;

    logic              wr_fire, rd_go, err_nz, in_ok, srv_ok, sel_ok;
    logic [CH_W-1:0]   serve, chsel;
    logic [PW-1:0]     sect, fill_sel;
    logic [WORD_W-1:0] wword, rword;
    logic              sop_s, eop_s;

    assign err_nz  = (ERR_W > 0) && (|in_err);
    assign in_ok   = 32'(in_ch) < NUM_CH;
    assign in_ready = in_ok && !occ_v[in_ch][ADDR_W];
    assign wr_fire = in_valid && in_ready;

    assign serve  = USE_REQ ? req_ch : '0;
    assign srv_ok = 32'(serve) < NUM_CH;
    assign rd_go  = srv_ok && avail_v[serve] && (!st_q.out_valid || out_ready);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign wr_sel[c]  = wr_fire && (32'(in_ch) == c);
            assign rd_sel[c]  = rd_go && (32'(serve) == c);
            assign avail_v[c] = (vis_v[c] != '0) && (USE_PKT || (vis_v[c] >= sect));

            mcf_chan_ptrs #(
                .ADDR_W  (ADDR_W),
                .PKT_EFF (PKT_EFF),
                .DROP_EFF(DROP_EFF)
            ) u_ptrs (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_sel[c]),
                .wr_eop (in_eop),
                .err_nz (err_nz),
                .rd_en  (rd_sel[c]),
                .occ    (occ_v[c]),
                .vis    (vis_v[c]),
                .wr_ptr (wptr_v[c]),
                .rd_ptr (rptr_v[c])
            );
        end
    endgenerate

    assign sop_s = USE_PKT ? in_sop : 1'b0;
    assign eop_s = USE_PKT ? in_eop : 1'b0;
    assign wword = {in_err, sop_s, eop_s, in_data};

    mcf_seg_ram #(
        .AW(RAM_AW),
        .W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (wr_fire),
        .waddr ({in_ch, wptr_v[in_ch]}),
        .wdata (wword),
        .re    (rd_go),
        .raddr ({serve, rptr_v[serve]}),
        .rdata (rword)
    );

    assign sel_ok   = 32'(chsel) < NUM_CH;
    assign fill_sel = sel_ok ? occ_v[chsel] : '0;

    mcf_status_regs #(
        .CH_W  (CH_W),
        .PW    (PW),
        .CSR_W (CSR_W),
        .NUM_AF(NUM_AF),
        .NUM_AE(NUM_AE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (csr_addr),
        .wr    (csr_wr),
        .wdata (csr_wdata),
        .fill  (fill_sel),
        .chsel (chsel),
        .sect  (sect),
        .rdata (csr_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (rd_go) begin
            st_d.out_valid = 1'b1;
            st_d.out_ch    = serve;
        end else if (out_ready) begin
            st_d.out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_ch    = st_q.out_ch;
    assign {out_err, out_sop, out_eop, out_data} = rword;

    // R6: a stalled output word stays put
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_ch) && $stable(out_err) && $stable(out_sop) && $stable(out_eop)));
endmodule

// File: tb/mcf_shared_fifo_bench.sv
`timescale 1ns/1ps
module mcf_shared_fifo_bench;
    import mcf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       in_valid [2];
    logic       in_ready [2];
    logic [7:0] in_data  [2];
    logic       in_ch    [2];
    logic       in_sop   [2];
    logic       in_eop   [2];
    logic [1:0] in_err   [2];
    logic       out_valid[2];
    logic       out_ready[2];
    logic [7:0] out_data [2];
    logic       out_ch   [2];
    logic       out_sop  [2];
    logic       out_eop  [2];
    logic [1:0] out_err  [2];
    logic       req_ch   [2];
    logic [2:0] csr_addr [2];
    logic       csr_wr   [2];
    logic [3:0] csr_wdata[2];
    logic [3:0] csr_rdata[2];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // packet-buffered, drop-on-error, request-driven instance
    mcf_shared_fifo u_mcf_shared_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid[0]), .in_ready(in_ready[0]), .in_data(in_data[0]),
        .in_ch(in_ch[0]), .in_sop(in_sop[0]), .in_eop(in_eop[0]), .in_err(in_err[0]),
        .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_data(out_data[0]),
        .out_ch(out_ch[0]), .out_sop(out_sop[0]), .out_eop(out_eop[0]), .out_err(out_err[0]),
        .req_ch(req_ch[0]), .csr_addr(csr_addr[0]), .csr_wr(csr_wr[0]),
        .csr_wdata(csr_wdata[0]), .csr_rdata(csr_rdata[0])
    );

    // plain stream instance: no packets, no request input
    mcf_shared_fifo #(
        .USE_PKT(1'b0), .PKT_BUF(1'b0), .DROP_ERR(1'b0), .USE_REQ(1'b0)
    ) u_mcf_shared_fifo_raw (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid[1]), .in_ready(in_ready[1]), .in_data(in_data[1]),
        .in_ch(in_ch[1]), .in_sop(in_sop[1]), .in_eop(in_eop[1]), .in_err(in_err[1]),
        .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_data(out_data[1]),
        .out_ch(out_ch[1]), .out_sop(out_sop[1]), .out_eop(out_eop[1]), .out_err(out_err[1]),
        .req_ch(req_ch[1]), .csr_addr(csr_addr[1]), .csr_wr(csr_wr[1]),
        .csr_wdata(csr_wdata[1]), .csr_rdata(csr_rdata[1])
    );

    typedef struct packed {
        logic       ch;
        logic       sop;
        logic       eop;
        logic [1:0] err;
        logic [7:0] data;
        logic       keep;
    } vec_t;

    localparam vec_t VEC [15] = '{
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h11, 1'b1},
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'h12, 1'b1},
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'h13, 1'b1},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h21, 1'b0},
        '{1'b1, 1'b0, 1'b1, 2'd2, 8'h22, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'h14, 1'b0},
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'h15, 1'b0},
        '{1'b1, 1'b1, 1'b1, 2'd0, 8'h23, 1'b1},
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h16, 1'b1},
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'h17, 1'b1},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h24, 1'b0},
        '{1'b1, 1'b0, 1'b0, 2'd3, 8'h25, 1'b0},
        '{1'b1, 1'b0, 1'b1, 2'd0, 8'h26, 1'b0},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h27, 1'b1},
        '{1'b1, 1'b0, 1'b1, 2'd0, 8'h28, 1'b1}
    };

    function automatic logic [31:0] pk(input logic ch, input logic [1:0] err,
                                       input logic sop, input logic eop, input logic [7:0] d);
        return {19'd0, ch, err, sop, eop, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input int i, input logic ch, input logic sop, input logic eop,
                        input logic [1:0] err, input logic [7:0] d);
        int n = 0;
        in_valid[i] = 1'b1; in_ch[i] = ch; in_sop[i] = sop; in_eop[i] = eop;
        in_err[i] = err; in_data[i] = d;
        #1;
        while (!in_ready[i] && n < 50) begin
            @(negedge clk); #1; n++;
        end
        if (!in_ready[i]) check("R1 input stalled", 32'd0, 32'd1);
        @(negedge clk);
        in_valid[i] = 1'b0;
    endtask

    task automatic pop(input int i, input logic [31:0] exp, input string req);
        int n = 0;
        while (!out_valid[i] && n < 20) begin
            @(negedge clk); n++;
        end
        if (!out_valid[i]) check(req, 32'hFFFF_FFFF, exp);
        else check(req, pk(out_ch[i], out_err[i], out_sop[i], out_eop[i], out_data[i]), exp);
        out_ready[i] = 1'b1;
        @(negedge clk);
        out_ready[i] = 1'b0;
    endtask

    task automatic csr_write(input int i, input logic [2:0] a, input logic [3:0] v);
        csr_addr[i] = a; csr_wdata[i] = v; csr_wr[i] = 1'b1;
        @(negedge clk);
        csr_wr[i] = 1'b0;
    endtask

    task automatic csr_read(input int i, input logic [2:0] a, output logic [3:0] v);
        csr_addr[i] = a;
        @(negedge clk);
        v = csr_rdata[i];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] rv;
        logic [7:0] held;
        for (int i = 0; i < 2; i++) begin
            in_valid[i] = 0; in_data[i] = 0; in_ch[i] = 0; in_sop[i] = 0; in_eop[i] = 0;
            in_err[i] = 0; out_ready[i] = 0; req_ch[i] = 0; csr_addr[i] = 0;
            csr_wr[i] = 0; csr_wdata[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state of both instances
        for (int i = 0; i < 2; i++) begin
            check("R10 out_valid idle", 32'(out_valid[i]), 32'd0);
            check("R10 in_ready high", 32'(in_ready[i]), 32'd1);
            csr_read(i, CSR_FILL, rv);
            check("R10 fill empty", 32'(rv), 32'd0);
            csr_read(i, CSR_AF2, rv);
            check("R10 threshold zero", 32'(rv), 32'd0);
        end

        csr_write(0, CSR_AF1, 4'd8);
        csr_write(0, CSR_AF2, 4'd4);
        csr_write(0, CSR_AE1, 4'd0);
        csr_write(0, CSR_AE2, 4'd8);

        // R4 R2: stimulus table, interleaved packets with drops
        for (int k = 0; k < 15; k++) begin
            push(0, VEC[k].ch, VEC[k].sop, VEC[k].eop, VEC[k].err, VEC[k].data);
        end
        repeat (3) @(negedge clk);
        csr_write(0, CSR_CHSEL, 4'd0);
        csr_read(0, CSR_FILL, rv);
        check("R7 fill ch0 after fetch of one word", 32'(rv), 32'd4);
        csr_write(0, CSR_CHSEL, 4'd1);
        csr_read(0, CSR_FILL, rv);
        check("R4 dropped space reclaimed ch1", 32'(rv), 32'd3);
        for (int c = 0; c < 2; c++) begin
            req_ch[0] = c[0];
            @(negedge clk);
            for (int k = 0; k < 15; k++) begin
                if (VEC[k].keep && VEC[k].ch == c[0])
                    pop(0, pk(VEC[k].ch, VEC[k].err, VEC[k].sop, VEC[k].eop, VEC[k].data),
                        "R2 R4 R5 table word");
            end
        end
        repeat (3) @(negedge clk);
        check("R4 nothing left after drops", 32'(out_valid[0]), 32'd0);

        // R3: open packet is not visible
        req_ch[0] = 1'b0;
        push(0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h31);
        repeat (3) @(negedge clk);
        check("R3 no output before end beat", 32'(out_valid[0]), 32'd0);
        csr_write(0, CSR_CHSEL, 4'd0);
        csr_read(0, CSR_FILL, rv);
        check("R7 fill counts open packet", 32'(rv), 32'd1);
        push(0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h32);
        pop(0, pk(1'b0, 2'd0, 1'b1, 1'b0, 8'h31), "R3 first word after commit");
        pop(0, pk(1'b0, 2'd0, 1'b0, 1'b1, 8'h32), "R3 end word");

        // R1: full channel
        for (int k = 0; k < 8; k++) begin
            push(0, 1'b1, k == 0, k == 7, 2'd0, 8'h40 + 8'(k));
        end
        in_ch[0] = 1'b1; #1;
        check("R1 full channel not ready", 32'(in_ready[0]), 32'd0);
        in_ch[0] = 1'b0; #1;
        check("R1 other channel ready", 32'(in_ready[0]), 32'd1);
        @(negedge clk);
        csr_write(0, CSR_CHSEL, 4'd1);
        csr_read(0, CSR_FILL, rv);
        check("R7 fill full", 32'(rv), 32'd8);
        csr_read(0, CSR_FLAGS, rv);
        check("R8 flags at full", 32'(rv), 32'hB);

        // R6: hold under back-pressure
        req_ch[0] = 1'b1;
        repeat (3) @(negedge clk);
        held = out_data[0];
        check("R6 word offered", 32'(out_valid[0]), 32'd1);
        repeat (3) @(negedge clk);
        check("R6 valid held", 32'(out_valid[0]), 32'd1);
        check("R6 data held", 32'(out_data[0]), 32'(held));
        for (int k = 0; k < 8; k++) begin
            pop(0, pk(1'b1, 2'd0, k == 0, k == 7, 8'h40 + 8'(k)), "R2 order after full");
        end
        csr_read(0, CSR_FLAGS, rv);
        check("R8 flags at empty", 32'(rv), 32'hC);

        // R9 R12 R11 on the plain stream instance
        csr_write(1, CSR_SECT, 4'd3);
        push(1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h51);
        push(1, 1'b0, 1'b0, 1'b0, 2'd1, 8'h52);
        repeat (3) @(negedge clk);
        check("R9 below section threshold", 32'(out_valid[1]), 32'd0);
        push(1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h53);
        pop(1, pk(1'b0, 2'd0, 1'b0, 1'b0, 8'h51), "R9 first word, markers zero");
        repeat (3) @(negedge clk);
        check("R9 stalls when count drops under threshold", 32'(out_valid[1]), 32'd0);
        push(1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h54);
        pop(1, pk(1'b0, 2'd1, 1'b0, 1'b0, 8'h52), "R12 error delivered");
        csr_write(1, CSR_SECT, 4'd0);
        pop(1, pk(1'b0, 2'd0, 1'b0, 1'b0, 8'h53), "R9 threshold zero");
        pop(1, pk(1'b0, 2'd0, 1'b0, 1'b0, 8'h54), "R9 threshold zero last");
        req_ch[1] = 1'b1;
        push(1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h61);
        repeat (4) @(negedge clk);
        check("R11 channel 1 never output", 32'(out_valid[1]), 32'd0);
        csr_write(1, CSR_CHSEL, 4'd1);
        csr_read(1, CSR_FILL, rv);
        check("R11 word kept in channel 1", 32'(rv), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule